// File: doc/BRIEF.md
# DRAM Geometry Aliasing Probe Responder

This block answers word-sized probe accesses the way an undersized DRAM part would if software programmed a geometry wider than the part really decodes. Boot code sizes memory by writing patterns at chosen offsets and reading them back. When two offsets land on the same physical cell, the second write overwrites the first, and the code infers the true row, bank and column widths from where the aliasing appears.

Each probe offset is a 32-bit word index. The block splits it into column, bank and row fields using the geometry that was last loaded. It then keeps only the low bits of each field that the real part has and uses them to select a cell in a small store. The store holds one word for every combination of real row, bank and column bits, and it only needs to be large enough to show aliasing. When the loaded geometry matches the real part on all three widths, no aliasing can occur. In that case the store is switched off: reads return zero and writes are dropped.

Top module: `dram_alias_probe`

## Requirements
- R1: After reset every cell reads as zero, `prb_rvld` and `prb_rdata` are low, and the loaded geometry equals the real widths, so the store starts switched off.
- R2: A probe offset is split with the column field in the lowest `col` bits, the bank field in the next `bank` bits and the row field in the `row` bits above those, using the loaded widths. Offset bits above the row field are ignored.
- R3: The cell index is {row[REAL_ROW-1:0], bank[REAL_BANK-1:0], col[REAL_COL-1:0]}. A field bit that the loaded geometry does not contain counts as zero.
- R4: The store is switched on exactly when the loaded row, bank or column width differs from the real width. The loaded widths and this decision change only on a cycle in which `cfg_upd` is high, and they take effect from the next cycle.
- R5: While the store is switched off, a read returns zero and a write is discarded. Cell contents written earlier are kept and become visible again once the store is switched back on.
- R6: A read (`prb_vld`=1, `prb_wr`=0) raises `prb_rvld` for one cycle on the following cycle, with the data in `prb_rdata`. On every other cycle `prb_rvld` is 0 and `prb_rdata` is zero.
- R7: A write (`prb_vld`=1, `prb_wr`=1) stores the full 32-bit word in the selected cell. Any two offsets that map to the same index read back the last word written to either of them.
- R8: A loaded row width above 16 is taken as 16, and a loaded column width above 13 is taken as 13. The bank width field is two bits wide, for a maximum of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_upd | input | 1 | Geometry load strobe |
| cfg_row_w | input | 5 | Programmed row width in bits |
| cfg_bank_w | input | 2 | Programmed bank width in bits |
| cfg_col_w | input | 4 | Programmed column width in bits |
| prb_vld | input | 1 | Probe access request |
| prb_wr | input | 1 | 1 = write, 0 = read |
| prb_addr | input | 32 | Probe offset in words |
| prb_wdata | input | 32 | Write word |
| prb_rvld | output | 1 | Read data valid |
| prb_rdata | output | 32 | Read data word |

## Verification
A wrong field boundary or a wrong truncation in the splitter shows up at the ports as aliasing between the wrong pairs of offsets. The first read-back after a full write sweep then returns a neighbour's word. A stale or wrong on/off decision shows up on the first read after a geometry load: the read returns zero where data was expected, or the reverse. A write that is not discarded while the store is off shows up on the first read after the store is switched back on. The benches sweep every offset of several small geometries. Each fault therefore shows within one sweep, on the read cycle that follows the offending access.

// File: rtl/dram_alias_pkg.sv
package dram_alias_pkg;
  localparam int ROW_MAX  = 16;
  localparam int BANK_MAX = 3;
  localparam int COL_MAX  = 13;
  localparam int RW_W = $clog2(ROW_MAX + 1);
  localparam int BW_W = $clog2(BANK_MAX + 1);
  localparam int CW_W = $clog2(COL_MAX + 1);

  typedef struct packed {
    logic [RW_W-1:0] row;
    logic [BW_W-1:0] bank;
    logic [CW_W-1:0] col;
  } geom_t;
endpackage

// File: rtl/alias_geom_reg.sv
module alias_geom_reg
  import dram_alias_pkg::*;
#(
  parameter int REAL_ROW  = 3,
  parameter int REAL_BANK = 2,
  parameter int REAL_COL  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [RW_W-1:0] row_in,
  input  logic [BW_W-1:0] bank_in,
  input  logic [CW_W-1:0] col_in,
  output geom_t           geom,
  output logic            alias_en
);
  geom_t geom_q, geom_d;
  logic  en_q, en_d;

  always_comb begin
    geom_d = geom_q;
    en_d   = en_q;
    if (upd) begin
      geom_d.row  = (row_in > RW_W'(ROW_MAX)) ? RW_W'(ROW_MAX) : row_in;
      geom_d.bank = bank_in;
      geom_d.col  = (col_in > CW_W'(COL_MAX)) ? CW_W'(COL_MAX) : col_in;
      en_d = (geom_d.row  != RW_W'(REAL_ROW))  ||
             (geom_d.bank != BW_W'(REAL_BANK)) ||
             (geom_d.col  != CW_W'(REAL_COL));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      geom_q.row  <= RW_W'(REAL_ROW);
      geom_q.bank <= BW_W'(REAL_BANK);
      geom_q.col  <= CW_W'(REAL_COL);
      en_q        <= 1'b0;
    end else if (upd) begin
      geom_q <= geom_d;
      en_q   <= en_d;
    end
  end

  assign geom     = geom_q;
  assign alias_en = en_q;
endmodule

// File: rtl/alias_addr_split.sv
module alias_addr_split
  import dram_alias_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REAL_ROW  = 3,
  parameter int REAL_BANK = 2,
  parameter int REAL_COL  = 3,
  localparam int IDX_W    = REAL_ROW + REAL_BANK + REAL_COL
) (
  input  geom_t             geom,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0]    above_col, above_bank;
  logic [REAL_COL-1:0]  col_t;
  logic [REAL_BANK-1:0] bank_t;
  logic [REAL_ROW-1:0]  row_t;

  always_comb begin
    above_col  = addr >> geom.col;
    above_bank = above_col >> geom.bank;
    col_t  = REAL_COL'(addr & ~(ONES << geom.col));
    bank_t = REAL_BANK'(above_col & ~(ONES << geom.bank));
    row_t  = REAL_ROW'(above_bank & ~(ONES << geom.row));
    idx    = {row_t, bank_t, col_t};
  end
endmodule

// File: rtl/alias_cell_store.sv
module alias_cell_store #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              wr,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvld,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cell_q [DEPTH];
  logic              rd_req, wr_req;
  logic [DATA_W-1:0] rdata_d;
  logic              rvld_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_req  = vld && !wr;
    wr_req  = vld && wr && en;
    rdata_d = (rd_req && en) ? cell_q[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (wr_req) begin
      cell_q[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rvld_q  <= rd_req;
      rdata_q <= rdata_d;
    end
  end

  assign rvld  = rvld_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/dram_alias_probe.sv
module dram_alias_probe
  import dram_alias_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REAL_ROW  = 3,
  parameter int REAL_BANK = 2,
  parameter int REAL_COL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_upd,
  input  logic [4:0]        cfg_row_w,
  input  logic [1:0]        cfg_bank_w,
  input  logic [3:0]        cfg_col_w,
  input  logic              prb_vld,
  input  logic              prb_wr,
  input  logic [ADDR_W-1:0] prb_addr,
  input  logic [DATA_W-1:0] prb_wdata,
  output logic              prb_rvld,
  output logic [DATA_W-1:0] prb_rdata
);
  localparam int IDX_W = REAL_ROW + REAL_BANK + REAL_COL;

  geom_t            geom;
  logic             alias_en;
  logic [IDX_W-1:0] cell_idx;

  alias_geom_reg #(
    .REAL_ROW (REAL_ROW),
    .REAL_BANK(REAL_BANK),
    .REAL_COL (REAL_COL)
  ) geom_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (cfg_upd),
    .row_in  (cfg_row_w),
    .bank_in (cfg_bank_w),
    .col_in  (cfg_col_w),
    .geom    (geom),
    .alias_en(alias_en)
  );

  alias_addr_split #(
    .ADDR_W   (ADDR_W),
    .REAL_ROW (REAL_ROW),
    .REAL_BANK(REAL_BANK),
    .REAL_COL (REAL_COL)
  ) split_i (
    .geom(geom),
    .addr(prb_addr),
    .idx (cell_idx)
  );

  alias_cell_store #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) store_i (
    .clk  (clk),
    .rst_n(rst_n),
    .vld  (prb_vld),
    .wr   (prb_wr),
    .en   (alias_en),
    .idx  (cell_idx),
    .wdata(prb_wdata),
    .rvld (prb_rvld),
    .rdata(prb_rdata)
  );
endmodule

// File: rtl/dram_alias_probe_chk.sv
module dram_alias_probe_chk #(
  parameter int DATA_W    = 32,
  parameter int REAL_ROW  = 3,
  parameter int REAL_BANK = 2,
  parameter int REAL_COL  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_upd,
  input logic [4:0]        cfg_row_w,
  input logic [1:0]        cfg_bank_w,
  input logic [3:0]        cfg_col_w,
  input logic              prb_vld,
  input logic              prb_wr,
  input logic              prb_rvld,
  input logic [DATA_W-1:0] prb_rdata,
  input logic              alias_en
);
  logic [4:0] row_c;
  logic [3:0] col_c;
  logic       differs;

  always_comb begin
    row_c   = (cfg_row_w > 5'd16) ? 5'd16 : cfg_row_w;
    col_c   = (cfg_col_w > 4'd13) ? 4'd13 : cfg_col_w;
    differs = (row_c != 5'(REAL_ROW)) || (cfg_bank_w != 2'(REAL_BANK)) ||
              (col_c != 4'(REAL_COL));
  end

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_vld && !prb_wr) |=> prb_rvld);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prb_vld && !prb_wr) |=> (!prb_rvld && prb_rdata == '0));

  // R5
  off_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_vld && !prb_wr && !alias_en) |=> (prb_rdata == '0));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |=> $stable(alias_en));

  // R4, R8
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |=> (alias_en == $past(differs)));
endmodule

bind dram_alias_probe dram_alias_probe_chk #(
  .DATA_W   (DATA_W),
  .REAL_ROW (REAL_ROW),
  .REAL_BANK(REAL_BANK),
  .REAL_COL (REAL_COL)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_upd   (cfg_upd),
  .cfg_row_w (cfg_row_w),
  .cfg_bank_w(cfg_bank_w),
  .cfg_col_w (cfg_col_w),
  .prb_vld   (prb_vld),
  .prb_wr    (prb_wr),
  .prb_rvld  (prb_rvld),
  .prb_rdata (prb_rdata),
  .alias_en  (alias_en)
);

// File: tb/dram_alias_probe_tb_top.sv
module dram_alias_probe_tb_top;
  localparam int RR = 3;
  localparam int RB = 2;
  localparam int RC = 3;
  localparam int NCELL = 2 ** (RR + RB + RC);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_upd = 1'b0;
  logic [4:0]  cfg_row_w = '0;
  logic [1:0]  cfg_bank_w = '0;
  logic [3:0]  cfg_col_w = '0;
  logic        prb_vld = 1'b0;
  logic        prb_wr = 1'b0;
  logic [31:0] prb_addr = '0;
  logic [31:0] prb_wdata = '0;
  logic        prb_rvld;
  logic [31:0] prb_rdata;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  int m_row = RR, m_bank = RB, m_col = RC;
  logic m_en = 1'b0;
  logic [31:0] mdl [NCELL];

  always #2.5 clk = ~clk;

  dram_alias_probe #(
    .REAL_ROW(RR), .REAL_BANK(RB), .REAL_COL(RC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_upd(cfg_upd),
    .cfg_row_w(cfg_row_w), .cfg_bank_w(cfg_bank_w), .cfg_col_w(cfg_col_w),
    .prb_vld(prb_vld), .prb_wr(prb_wr), .prb_addr(prb_addr),
    .prb_wdata(prb_wdata), .prb_rvld(prb_rvld), .prb_rdata(prb_rdata)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic int cell_of(input longint a);
    longint c, b, r;
    c = a % (longint'(1) << m_col);
    b = (a / (longint'(1) << m_col)) % (longint'(1) << m_bank);
    r = (a / (longint'(1) << (m_col + m_bank))) % (longint'(1) << m_row);
    return int'(((r % (2 ** RR)) * (2 ** RB) + (b % (2 ** RB))) * (2 ** RC)
                + (c % (2 ** RC)));
  endfunction

  task automatic load_geom(input int r, input int b, input int c);
    @(negedge clk);
    cfg_upd = 1'b1; cfg_row_w = 5'(r); cfg_bank_w = 2'(b); cfg_col_w = 4'(c);
    @(negedge clk);
    cfg_upd = 1'b0;
    m_row  = (r > 16) ? 16 : r;
    m_bank = b;
    m_col  = (c > 13) ? 13 : c;
    m_en   = (m_row != RR) || (m_bank != RB) || (m_col != RC);
  endtask

  task automatic wr(input longint a, input logic [31:0] d);
    @(negedge clk);
    prb_vld = 1'b1; prb_wr = 1'b1; prb_addr = 32'(a); prb_wdata = d;
    @(negedge clk);
    prb_vld = 1'b0; prb_wr = 1'b0;
    if (m_en) mdl[cell_of(a)] = d;
  endtask

  task automatic rd_chk(input longint a, input string req);
    logic [31:0] exp;
    exp = m_en ? mdl[cell_of(a)] : 32'h0;
    @(negedge clk);
    prb_vld = 1'b1; prb_wr = 1'b0; prb_addr = 32'(a);
    @(negedge clk);
    prb_vld = 1'b0;
    check(prb_rvld === 1'b1, {req, " rvld"}, {31'h0, prb_rvld}, 32'h1);
    check(prb_rdata === exp, req, prb_rdata, exp);
  endtask

  function automatic logic [31:0] pat(input int a, input int seed);
    return 32'(a) * 32'h9E37_79B9 ^ 32'(seed);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCELL; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(prb_rvld === 1'b0 && prb_rdata === 32'h0, "R1 reset outputs",
          prb_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: no read, outputs quiet
    check(prb_rvld === 1'b0, "R6 idle rvld", {31'h0, prb_rvld}, 32'h0);
    // R1: geometry equals real part, store off, read is zero
    rd_chk(5, "R1 off after reset");

    // R4: wider geometry switches store on; R1 cells start at zero
    load_geom(5, 3, 4);
    for (int a = 0; a < 4096; a += 97) rd_chk(a, "R1 cell zero");
    // R2 R3 R7: full sweep of a 12-bit space over 256 cells
    for (int a = 0; a < 4096; a++) wr(a, pat(a, 32'h11));
    for (int a = 0; a < 4096; a++) rd_chk(a, "R7 alias 5/3/4");

    // R5: matching geometry turns store off, write discarded, data kept
    load_geom(RR, RB, RC);
    rd_chk(7, "R5 off read zero");
    wr(7, 32'hDEAD_BEEF);
    load_geom(5, 3, 4);
    rd_chk(7, "R5 write discarded");
    rd_chk(4095, "R5 contents kept");

    // R2 R3: narrower geometry; offsets above row field ignored
    load_geom(2, 1, 2);
    for (int a = 0; a < 32; a++) wr(a, pat(a, 32'h22));
    for (int a = 0; a < 128; a++) rd_chk(a, "R2 narrow wrap");

    // R4: only column width differs still enables
    load_geom(RR, RB, 2);
    for (int a = 0; a < 128; a++) wr(a, pat(a, 32'h33));
    for (int a = 0; a < 256; a++) rd_chk(a, "R4 col-only mismatch");

    // R8: column width 15 is taken as 13, so offset bit 13 is bank bit 0
    load_geom(20, 3, 15);
    wr(0, 32'h0BAD_F00D);
    wr(longint'(1) << 13, 32'h1234_5678);
    rd_chk(0, "R8 col clamp");
    rd_chk(longint'(1) << 13, "R8 col clamp bank");
    // R8: row 20 taken as 16, max geometry sweep of high offsets
    for (int k = 0; k < 32; k++) wr(longint'(k) << 27, pat(k, 32'h44));
    for (int k = 0; k < 32; k++) rd_chk(longint'(k) << 27, "R8 row clamp");

    // R6: read data returns to zero after the valid cycle
    @(negedge clk);
    check(prb_rvld === 1'b0 && prb_rdata === 32'h0, "R6 data quiet",
          prb_rdata, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule